// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block lets a load-store core do atomic read-modify-write sequences on shared memory without locking the bus. A linked load returns the memory word and arms one reservation on the cache line that holds that word. A later conditional store to the same line writes memory only if nothing has disturbed that line in the meantime. The store's result comes back on the response data bus as 1 for success or 0 for failure. Software retries the sequence until the store succeeds.

The reservation is dropped by several events. Other agents report modified or invalidated lines through one or more snoop ports, and a hit on the reserved line drops it. So do an exception return and any conditional store. Addresses in the non-cacheable region never arm the reservation. Comparison is on whole cache lines, so a snoop to a neighbouring word in the same line also cancels the reservation. Memory and caches sit outside. The block drives a registered write strobe with its address and data, and takes the addressed memory word as an input alongside each request.

Top module: `llsc_monitor`

## Requirements
- R1: A request accepted on a clock edge yields `rsp_valid` for exactly the next cycle. For a linked load (`req_op`=0), `rsp_sc` is 0, `rsp_data` equals the `mem_rdata` presented with the request, and `mem_we` stays low.
- R2: A conditional store (`req_op`=1) to the line of a valid reservation raises `mem_we` for one cycle, with `mem_addr`/`mem_wdata` equal to the request's address and data, and returns `rsp_data`=1.
- R3: A conditional store with no valid matching reservation leaves `mem_we` low and returns `rsp_data`=0.
- R4: A valid snoop on any port whose line equals the reserved line clears the reservation. Snoops to other lines leave it intact.
- R5: `eret` clears the reservation. A conditional store in the same cycle as `eret` fails.
- R6: Lines are compared with the low log2(`LINE_BYTES`) address bits ignored (5 bits by default). This applies both to store matching and to snoop matching.
- R7: A linked load to a non-cacheable address does not arm a reservation. By default an address is non-cacheable when bit 31 is set.
- R8: Every conditional store clears the reservation, whether it succeeds or fails.
- R9: A new linked load replaces any existing reservation.
- R10: A snoop on the line in the same cycle as a conditional store makes that store fail. A snoop on the line in the same cycle as a linked load leaves no reservation.
- R11: After reset no reservation is held, and `rsp_valid` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_op | input | 1 | 0 = linked load, 1 = conditional store |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Store data |
| mem_rdata | input | DW | Memory word at `req_addr`, presented with a linked load |
| snp_valid | input | NSNP | Per-port snoop valid (line modified or invalidated) |
| snp_addr | input | NSNP*AW | Per-port snoop address, port i at bits [i*AW +: AW] |
| eret | input | 1 | Exception return executed |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_sc | output | 1 | Response belongs to a conditional store |
| rsp_data | output | DW | Loaded word, or store success flag in bit 0 |

## Verification
Every cycle, the assertions check the following. A write strobe only ever accompanies a successful store response. A failed store never writes. Every request is answered on the next cycle. A conditional store, an uncached linked load or a same-cycle exception return always leaves the reservation cleared or the write suppressed. The bench scenarios cover the behaviour that depends on history: arming followed by success, replacement by a second linked load, cancellation by a snoop to a neighbouring word versus survival of a snoop to another line, and snoops arriving on the second port.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic {
    OP_LINK_LOAD  = 1'b0,
    OP_COND_STORE = 1'b1
  } llsc_op_e;
endpackage

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
  parameter int LW = 27
) (
  input  logic [LW-1:0] line_a,
  input  logic [LW-1:0] line_b,
  output logic          same
);
  assign same = (line_a == line_b);
endmodule

// File: rtl/llsc_region.sv
module llsc_region #(
  parameter int          AW       = 32,
  parameter logic [31:0] UC_MASK  = 32'h8000_0000,
  parameter logic [31:0] UC_MATCH = 32'h8000_0000
) (
  input  logic [AW-1:0] addr,
  output logic          cacheable
);
  localparam logic [AW-1:0] MASK  = UC_MASK[AW-1:0];
  localparam logic [AW-1:0] MATCH = UC_MATCH[AW-1:0];
  assign cacheable = ((addr & MASK) != MATCH);
endmodule

// File: rtl/llsc_snoop_hits.sv
module llsc_snoop_hits #(
  parameter int NSNP = 2,
  parameter int LW   = 27
) (
  input  logic [NSNP-1:0]    snp_valid,
  input  logic [NSNP*LW-1:0] snp_lines,
  input  logic [LW-1:0]      rsv_line,
  input  logic [LW-1:0]      req_line,
  output logic               hit_rsv,
  output logic               hit_req
);
  logic [NSNP-1:0] eq_rsv;
  logic [NSNP-1:0] eq_req;

  for (genvar i = 0; i < NSNP; i++) begin : g_port
    llsc_line_match #(.LW(LW)) u_m_rsv (
      .line_a(snp_lines[i*LW +: LW]),
      .line_b(rsv_line),
      .same  (eq_rsv[i])
    );
    llsc_line_match #(.LW(LW)) u_m_req (
      .line_a(snp_lines[i*LW +: LW]),
      .line_b(req_line),
      .same  (eq_req[i])
    );
  end

  assign hit_rsv = |(snp_valid & eq_rsv);
  assign hit_req = |(snp_valid & eq_req);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          LINE_BYTES = 32,
  parameter int          NSNP       = 2,
  parameter logic [31:0] UC_MASK    = 32'h8000_0000,
  parameter logic [31:0] UC_MATCH   = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [NSNP-1:0]   snp_valid,
  input  logic [NSNP*AW-1:0] snp_addr,
  input  logic              eret,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              rsp_valid,
  output logic              rsp_sc,
  output logic [DW-1:0]     rsp_data
);
  localparam int OFF = $clog2(LINE_BYTES);
  localparam int LW  = AW - OFF;

  llsc_op_e         op;
  logic             is_ll, is_sc;
  logic [LW-1:0]    req_line;
  logic [NSNP*LW-1:0] snp_lines;
  logic [NSNP*OFF-1:0] snp_low;
  logic             unused_snp_low;

  logic             rsv_valid;
  logic [LW-1:0]    rsv_line;

  logic             hit_rsv, hit_req, line_same, cacheable;
  logic             kill_rsv, sc_ok;

  assign op       = llsc_op_e'(req_op);
  assign is_ll    = req_valid && (op == OP_LINK_LOAD);
  assign is_sc    = req_valid && (op == OP_COND_STORE);
  assign req_line = req_addr[AW-1:OFF];

  for (genvar i = 0; i < NSNP; i++) begin : g_split
    assign snp_lines[i*LW +: LW]  = snp_addr[i*AW+OFF +: LW];
    assign snp_low[i*OFF +: OFF]  = snp_addr[i*AW +: OFF];
  end
  assign unused_snp_low = ^snp_low;

  llsc_snoop_hits #(.NSNP(NSNP), .LW(LW)) u_snoop (
    .snp_valid(snp_valid),
    .snp_lines(snp_lines),
    .rsv_line (rsv_line),
    .req_line (req_line),
    .hit_rsv  (hit_rsv),
    .hit_req  (hit_req)
  );

  llsc_line_match #(.LW(LW)) u_sc_match (
    .line_a(rsv_line),
    .line_b(req_line),
    .same  (line_same)
  );

  llsc_region #(.AW(AW), .UC_MASK(UC_MASK), .UC_MATCH(UC_MATCH)) u_region (
    .addr     (req_addr),
    .cacheable(cacheable)
  );

  // Clearing events take priority over a store in the same cycle.
  assign kill_rsv = hit_rsv || eret;
  assign sc_ok    = is_sc && rsv_valid && line_same && !kill_rsv;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsv_valid <= 1'b0;
      rsv_line  <= '0;
    end else if (is_ll) begin
      rsv_valid <= cacheable && !hit_req && !eret;
      rsv_line  <= req_line;
    end else if (is_sc || kill_rsv) begin
      rsv_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_sc    <= 1'b0;
      rsp_data  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_sc    <= is_sc;
      rsp_data  <= is_sc ? {{(DW-1){1'b0}}, sc_ok} : mem_rdata;
      mem_we    <= sc_ok;
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          LINE_BYTES = 32,
  parameter int          NSNP       = 2,
  parameter logic [31:0] UC_MASK    = 32'h8000_0000,
  parameter logic [31:0] UC_MATCH   = 32'h8000_0000
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_op,
  input logic [AW-1:0]      req_addr,
  input logic [NSNP-1:0]    snp_valid,
  input logic [NSNP*AW-1:0] snp_addr,
  input logic               eret,
  input logic               mem_we,
  input logic               rsp_valid,
  input logic               rsp_sc,
  input logic [DW-1:0]      rsp_data,
  input logic               rsv_valid
);
  localparam int OFF = $clog2(LINE_BYTES);

  logic uncached, snoop0_same;
  assign uncached    = ((req_addr & UC_MASK[AW-1:0]) == UC_MATCH[AW-1:0]);
  assign snoop0_same = snp_valid[0] && ((snp_addr[AW-1:0] >> OFF) == (req_addr >> OFF));

  p_rsp_next_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_we_only_on_success_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (rsp_valid && rsp_sc && rsp_data == DW'(1)));

  p_fail_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_sc && rsp_data == '0) |-> !mem_we);

  p_eret_blocks_store_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op && eret) |=> !mem_we);

  p_uncached_no_rsv_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op && uncached) |=> !rsv_valid);

  p_store_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op) |=> !rsv_valid);

  p_snoop_beats_store_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op && snoop0_same) |=> !mem_we);

  p_flag_width_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_sc) |-> (rsp_data[DW-1:1] == '0));
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES), .NSNP(NSNP),
  .UC_MASK(UC_MASK), .UC_MATCH(UC_MATCH)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
  .eret(eret), .mem_we(mem_we), .rsp_valid(rsp_valid), .rsp_sc(rsp_sc),
  .rsp_data(rsp_data), .rsv_valid(rsv_valid)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NSNP = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_op = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic [DW-1:0]     mem_rdata = '0;
  logic [NSNP-1:0]   snp_valid = '0;
  logic [NSNP*AW-1:0] snp_addr = '0;
  logic              eret = 1'b0;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic              rsp_valid;
  logic              rsp_sc;
  logic [DW-1:0]     rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor u_llsc_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .eret(eret),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_sc(rsp_sc), .rsp_data(rsp_data)
  );

  typedef struct {
    bit          sc;
    bit          we;
    logic [31:0] data;
    logic [31:0] addr;
    logic [31:0] wdata;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  // Bench-side reservation model
  bit          m_valid = 0;
  logic [26:0] m_line  = '0;

  localparam logic [31:0] A  = 32'h0000_1000;
  localparam logic [31:0] A2 = 32'h0000_1014;
  localparam logic [31:0] B  = 32'h0000_1020;
  localparam logic [31:0] U  = 32'h8000_0040;

  function automatic logic [26:0] ln(input logic [31:0] a);
    return a[31:5];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input bit v, input bit sc, input logic [31:0] addr,
                      input logic [31:0] wd, input logic [31:0] rd,
                      input logic [1:0] sv, input logic [31:0] s0,
                      input logic [31:0] s1, input bit er, input string tag);
    bit hit_rsv, hit_req, ok;
    exp_t e;
    @(negedge clk);
    req_valid = v; req_op = sc; req_addr = addr; req_wdata = wd; mem_rdata = rd;
    snp_valid = sv; snp_addr = {s1, s0}; eret = er;
    hit_rsv = (sv[0] && ln(s0) == m_line) || (sv[1] && ln(s1) == m_line);
    hit_req = (sv[0] && ln(s0) == ln(addr)) || (sv[1] && ln(s1) == ln(addr));
    ok = v && sc && m_valid && (ln(addr) == m_line) && !hit_rsv && !er;
    if (v) begin
      e.sc = sc; e.we = ok; e.data = sc ? {31'b0, ok} : rd;
      e.addr = addr; e.wdata = wd; e.tag = tag;
      sb.push_back(e);
    end
    if (v && !sc) begin
      m_valid = !addr[31] && !hit_req && !er;
      m_line  = ln(addr);
    end else if ((v && sc) || hit_rsv || er) begin
      m_valid = 0;
    end
  endtask

  task automatic idle();
    step(0, 0, '0, '0, '0, 2'b00, '0, '0, 0, "idle");
  endtask

  task automatic ll(input logic [31:0] a, input logic [31:0] rd, input string tag);
    step(1, 0, a, '0, rd, 2'b00, '0, '0, 0, tag);
  endtask

  task automatic sc(input logic [31:0] a, input logic [31:0] wd, input string tag);
    step(1, 1, a, wd, '0, 2'b00, '0, '0, 0, tag);
  endtask

  // Monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(0, "R1 unexpected response", {31'b0, rsp_valid}, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_sc == e.sc, {e.tag, " rsp_sc"}, {31'b0, rsp_sc}, {31'b0, e.sc});
          check(rsp_data == e.data, {e.tag, " rsp_data"}, rsp_data, e.data);
          check(mem_we == e.we, {e.tag, " mem_we"}, {31'b0, mem_we}, {31'b0, e.we});
          if (e.we) begin
            check(mem_addr == e.addr, {e.tag, " mem_addr"}, mem_addr, e.addr);
            check(mem_wdata == e.wdata, {e.tag, " mem_wdata"}, mem_wdata, e.wdata);
          end
        end
      end else begin
        check(!mem_we, "R2 strobe without response", {31'b0, mem_we}, 32'h0);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(rsp_valid == 1'b0, "R11 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    check(mem_we == 1'b0, "R11 mem_we after reset", {31'b0, mem_we}, 32'h0);

    sc(A, 32'h0000_00aa, "R11 R3 store right after reset");
    ll(A, 32'hdead_0001, "R1 linked load data");
    sc(A, 32'h1111_1111, "R2 store succeeds");
    sc(A, 32'h2222_2222, "R8 R3 second store fails");

    ll(A, 32'h0000_0005, "R1 load");
    sc(A2, 32'h3333_3333, "R6 store to other word in line");

    ll(A, 32'h0000_0006, "R1 load");
    step(0, 0, '0, '0, '0, 2'b01, '0, A2, 0, "snoop");
    step(0, 0, '0, '0, '0, 2'b01, A2, '0, 0, "snoop");
    sc(A, 32'h4444_4444, "R4 R6 snoop on neighbour word cancels");

    ll(A, 32'h0000_0007, "R1 load");
    step(0, 0, '0, '0, '0, 2'b10, A2, B, 0, "snoop");
    sc(A, 32'h5555_5555, "R4 other-line snoop keeps reservation");

    ll(A, 32'h0000_0008, "R1 load");
    step(0, 0, '0, '0, '0, 2'b10, '0, A, 0, "snoop");
    sc(A, 32'h5656_5656, "R4 snoop on port 1 cancels");

    ll(A, 32'h0000_0009, "R1 load");
    step(0, 0, '0, '0, '0, 2'b00, '0, '0, 1, "eret");
    sc(A, 32'h6666_6666, "R5 eret cancels");

    ll(A, 32'h0000_000a, "R1 load");
    step(1, 1, A, 32'h7777_7777, '0, 2'b00, '0, '0, 1, "R5 store with same-cycle eret");

    ll(U, 32'h0000_000b, "R7 uncached load data");
    sc(U, 32'h8888_8888, "R7 store to uncached fails");

    ll(A, 32'h0000_000c, "R9 first load");
    ll(B, 32'h0000_000d, "R9 second load");
    sc(A, 32'h9999_9999, "R9 store to replaced line fails");
    ll(A, 32'h0000_000e, "R9 first load");
    ll(B, 32'h0000_000f, "R9 second load");
    sc(B, 32'haaaa_aaaa, "R9 store to newest line succeeds");

    ll(A, 32'h0000_0010, "R1 load");
    step(1, 1, A, 32'hbbbb_bbbb, '0, 2'b01, A2, '0, 0, "R10 same-cycle snoop beats store");

    step(1, 0, A, '0, 32'h0000_0011, 2'b10, '0, A, 0, "R10 load with same-cycle snoop");
    sc(A, 32'hcccc_cccc, "R10 store after snooped load fails");

    ll(B, 32'h0000_0012, "R1 load");
    sc(B + 32'h1c, 32'hdddd_dddd, "R2 R6 store to last word of line");

    idle();
    idle();
    idle();
    check(sb.size() == 0, "R1 responses outstanding", sb.size(), 32'h0);
    finish_run();
  end
endmodule